// File: doc/BRIEF.md
# Field-Masked DSP Control Register

This block holds the 32-bit control and status word of a DSP extension. It has two access paths. A write path updates only the fields picked by a 6-bit field-select mask. A read path returns the stored word with every field whose select bit is clear forced to zero. Each field has its own select bit, so software can change the carry bit without touching the shift count, for example. A read can also fetch just the condition codes.

The stored word has six fields:

| Field | Bits | Select bit |
|---|---|---|
| position | 5..0 | 0 |
| shift count | 12..7 | 1 |
| carry | 13 | 2 |
| overflow flags | 23..16 | 3 |
| condition codes | 31..24 | 4 |
| extract-fail | 14 | 5 |

Bits 15 and 6 belong to no field.

A parameter picks the architecture variant. In the 32-bit variant, only condition-code bits 27..24 exist. In the 64-bit variant, all eight condition-code bits are kept.

Top module: `dspctl_reg`

## Requirements
- R1: While reset is asserted and after it is released, with no write since, a read with select mask 0x3F returns 0x00000000.
- R2: When `wr_en` is high at a rising clock edge, each field whose `wr_mask` bit is set takes the value of the matching bits of `wr_data`. The mask bits map as follows: bit 0 position[5:0], bit 1 shift count[12:7], bit 2 carry[13], bit 3 overflow flags[23:16], bit 4 condition codes[31:24], bit 5 extract-fail[14].
- R3: On a write, every field whose `wr_mask` bit is clear keeps its previous value.
- R4: When `wr_en` is low at a clock edge, no field changes, whatever `wr_data` and `wr_mask` hold.
- R5: `rd_data` carries each stored field whose `rd_mask` bit is set, using the same bit mapping as R2. Every field whose `rd_mask` bit is clear reads as zero.
- R6: A write with mask 0x3F followed by a read with mask 0x3F returns the written word. The only differences are bits 15 and 6 and, in the 32-bit variant, bits 31..28, all of which read as zero.
- R7: In the 32-bit variant (`WIDE_CC` = 0), `wr_data[31:28]` is ignored and `rd_data[31:28]` is always zero.
- R8: In the 64-bit variant (`WIDE_CC` = 1), all eight condition-code bits [31:24] are stored and read back.
- R9: `rd_data[15]` and `rd_data[6]` are always zero.
- R10: `rd_data` follows a change of `rd_mask` in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write word, aligned to the field layout |
| wr_mask | input | 6 | Field-select mask for the write |
| rd_mask | input | 6 | Field-select mask for the read |
| rd_data | output | 32 | Stored word with unselected fields cleared |

## Verification
The main write path is driven with several data words:
- All ones shows which bits are really stored and which read as zero.
- An alternating pattern catches swapped or shifted field boundaries.
- A word with distinct values in every field catches two fields whose select bits are crossed.

Single-bit write masks, applied one at a time over a known background, show that each select bit reaches exactly its own field. Single-bit read masks over a full word do the same for the read path. A write with the strobe low, with a full mask, shows whether the strobe really gates the update. The same stimulus goes to both variants, which separates the hardwired upper condition-code bits from the stored ones.

// File: rtl/dspctl_pkg.sv
package dspctl_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned NFIELD  = 6;

  // select-mask bit index per field
  localparam int unsigned SEL_POS = 0;
  localparam int unsigned SEL_SC  = 1;
  localparam int unsigned SEL_CY  = 2;
  localparam int unsigned SEL_OV  = 3;
  localparam int unsigned SEL_CC  = 4;
  localparam int unsigned SEL_XF  = 5;

  // field placement in the word
  localparam int unsigned POS_LSB = 0;
  localparam int unsigned POS_W   = 6;
  localparam int unsigned SC_LSB  = 7;
  localparam int unsigned SC_W    = 6;
  localparam int unsigned CY_BIT  = 13;
  localparam int unsigned XF_BIT  = 14;
  localparam int unsigned OV_LSB  = 16;
  localparam int unsigned OV_W    = 8;
  localparam int unsigned CC_LSB  = 24;
  localparam int unsigned CC_W    = 8;
  localparam int unsigned CC_NARROW_W = 4;

  typedef struct packed {
    logic [CC_W-1:0]  cc;
    logic [OV_W-1:0]  ov;
    logic             xf;
    logic             cy;
    logic [SC_W-1:0]  sc;
    logic [POS_W-1:0] pos;
  } dspctl_fields_t;
endpackage

// File: rtl/dspctl_field.sv
module dspctl_field #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  // R3
  field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q));

  // R2
  field_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (q == $past(d)));
endmodule

// File: rtl/dspctl_ccond.sv
module dspctl_ccond
  import dspctl_pkg::*;
#(
  parameter bit WIDE_CC = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [CC_W-1:0] d,
  output logic [CC_W-1:0] q
);
  generate
    if (WIDE_CC) begin : g_wide
      dspctl_field #(.W(CC_W)) u_cc (
        .clk(clk), .rst_n(rst_n), .en(en), .d(d), .q(q));
    end else begin : g_narrow
      logic [CC_NARROW_W-1:0] lo_q;
      logic                   unused_hi;
      assign unused_hi = ^d[CC_W-1:CC_NARROW_W];
      dspctl_field #(.W(CC_NARROW_W)) u_cc (
        .clk(clk), .rst_n(rst_n), .en(en),
        .d(d[CC_NARROW_W-1:0]), .q(lo_q));
      assign q = {{(CC_W-CC_NARROW_W){1'b0}}, lo_q};

      // R7
      cc_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q[CC_W-1:CC_NARROW_W] == '0);
    end
  endgenerate
endmodule

// File: rtl/dspctl_pack.sv
module dspctl_pack
  import dspctl_pkg::*;
(
  input  dspctl_fields_t    fld,
  input  logic [NFIELD-1:0] sel,
  output logic [WORD_W-1:0] word
);
  always_comb begin
    word = '0;
    if (sel[SEL_POS]) word[POS_LSB +: POS_W] = fld.pos;
    if (sel[SEL_SC])  word[SC_LSB  +: SC_W]  = fld.sc;
    if (sel[SEL_CY])  word[CY_BIT]           = fld.cy;
    if (sel[SEL_XF])  word[XF_BIT]           = fld.xf;
    if (sel[SEL_OV])  word[OV_LSB  +: OV_W]  = fld.ov;
    if (sel[SEL_CC])  word[CC_LSB  +: CC_W]  = fld.cc;
  end
endmodule

// File: rtl/dspctl_reg.sv
module dspctl_reg
  import dspctl_pkg::*;
#(
  parameter bit WIDE_CC = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [NFIELD-1:0] wr_mask,
  input  logic [NFIELD-1:0] rd_mask,
  output logic [WORD_W-1:0] rd_data
);
  logic [NFIELD-1:0] fld_we;
  dspctl_fields_t    fld_q;
  logic              unused_rsvd;

  assign fld_we      = {NFIELD{wr_en}} & wr_mask;
  assign unused_rsvd = wr_data[15] ^ wr_data[6];

  dspctl_field #(.W(POS_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .en(fld_we[SEL_POS]),
    .d(wr_data[POS_LSB +: POS_W]), .q(fld_q.pos));

  dspctl_field #(.W(SC_W)) u_sc (
    .clk(clk), .rst_n(rst_n), .en(fld_we[SEL_SC]),
    .d(wr_data[SC_LSB +: SC_W]), .q(fld_q.sc));

  dspctl_field #(.W(1)) u_cy (
    .clk(clk), .rst_n(rst_n), .en(fld_we[SEL_CY]),
    .d(wr_data[CY_BIT]), .q(fld_q.cy));

  dspctl_field #(.W(1)) u_xf (
    .clk(clk), .rst_n(rst_n), .en(fld_we[SEL_XF]),
    .d(wr_data[XF_BIT]), .q(fld_q.xf));

  dspctl_field #(.W(OV_W)) u_ov (
    .clk(clk), .rst_n(rst_n), .en(fld_we[SEL_OV]),
    .d(wr_data[OV_LSB +: OV_W]), .q(fld_q.ov));

  dspctl_ccond #(.WIDE_CC(WIDE_CC)) u_cc (
    .clk(clk), .rst_n(rst_n), .en(fld_we[SEL_CC]),
    .d(wr_data[CC_LSB +: CC_W]), .q(fld_q.cc));

  dspctl_pack u_pack (.fld(fld_q), .sel(rd_mask), .word(rd_data));

  // R9
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[15] == 1'b0) && (rd_data[6] == 1'b0));

  // R5
  rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_mask[SEL_OV] |-> rd_data[OV_LSB +: OV_W] == '0) and
    (!rd_mask[SEL_POS] |-> rd_data[POS_LSB +: POS_W] == '0));

  // R4
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(fld_q));
endmodule

// File: tb/dspctl_reg_bench.sv
module dspctl_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [5:0]  wr_mask = '0;
  logic [5:0]  rd_mask = '0;
  logic [31:0] rd_n, rd_w;
  logic [31:0] exp_n, exp_w;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  dspctl_reg #(.WIDE_CC(1'b0)) u_dspctl_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_mask(wr_mask), .rd_mask(rd_mask), .rd_data(rd_n));

  dspctl_reg #(.WIDE_CC(1'b1)) u_dspctl_reg_wide (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_mask(wr_mask), .rd_mask(rd_mask), .rd_data(rd_w));

  function automatic logic [31:0] bits_of(input logic [5:0] m, input bit wide);
    logic [31:0] b = '0;
    if (m[0]) b |= 32'h0000_003F;
    if (m[1]) b |= 32'h0000_1F80;
    if (m[2]) b |= 32'h0000_2000;
    if (m[3]) b |= 32'h00FF_0000;
    if (m[4]) b |= wide ? 32'hFF00_0000 : 32'h0F00_0000;
    if (m[5]) b |= 32'h0000_4000;
    return b;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic en, input logic [31:0] d, input logic [5:0] m);
    @(negedge clk);
    wr_en = en; wr_data = d; wr_mask = m;
    if (en) begin
      exp_n = (exp_n & ~bits_of(m, 1'b0)) | (d & bits_of(m, 1'b0));
      exp_w = (exp_w & ~bits_of(m, 1'b1)) | (d & bits_of(m, 1'b1));
    end
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic check_read(input string req, input logic [5:0] m);
    rd_mask = m; #1;
    check({req, " narrow"}, rd_n, exp_n & bits_of(m, 1'b0));
    check({req, " wide"},   rd_w, exp_w & bits_of(m, 1'b1));
  endtask

  task automatic t_reset;
    rd_mask = 6'h3F; #1;
    check("R1 in reset", rd_n | rd_w, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check_read("R1 after release", 6'h3F);
  endtask

  task automatic t_full_roundtrip;
    do_write(1'b1, 32'hFFFF_FFFF, 6'h3F);
    check_read("R6 ones", 6'h3F);
    check("R7 narrow hi zero", rd_n & 32'hF000_0000, 32'h0);
    check("R8 wide hi kept", rd_w & 32'hF000_0000, 32'hF000_0000);
    check("R9 reserved zero", (rd_n | rd_w) & 32'h0000_8040, 32'h0);
    do_write(1'b1, 32'hAC35_6A8B, 6'h3F);
    check_read("R6 mixed", 6'h3F);
    do_write(1'b1, 32'h5555_5555, 6'h3F);
    check_read("R6 alt", 6'h3F);
  endtask

  task automatic t_single_fields;
    for (int i = 0; i < 6; i++) begin
      do_write(1'b1, 32'h0, 6'h3F);
      do_write(1'b1, 32'hFFFF_FFFF, 6'(1 << i));
      check_read("R2 R3 single field", 6'h3F);
    end
  endtask

  task automatic t_strobe_low;
    do_write(1'b1, 32'h1234_5678, 6'h3F);
    do_write(1'b0, 32'hEDCB_A987, 6'h3F);
    check_read("R4 strobe low", 6'h3F);
  endtask

  task automatic t_read_masks;
    do_write(1'b1, 32'hFFFF_FFFF, 6'h3F);
    for (int i = 0; i < 6; i++) check_read("R5 read field", 6'(1 << i));
    check_read("R5 none", 6'h00);
  endtask

  task automatic t_comb_read;
    @(negedge clk);
    rd_mask = 6'h08; #1;
    check("R10 same cycle", rd_n, 32'h00FF_0000);
    rd_mask = 6'h10; #1;
    check("R10 same cycle cc", rd_w, 32'hFF00_0000);
  endtask

  initial begin
    exp_n = '0; exp_w = '0;
    repeat (2) @(posedge clk);
    t_reset();
    t_full_roundtrip();
    t_single_fields();
    t_strobe_low();
    t_read_masks();
    t_comb_read();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule